// File: doc/BRIEF.md
# Supply and Temperature Fault Supervisor

This block watches two digitised quantities every clock: a supply-voltage code and a die-temperature code. It compares each one against thresholds that software programs through a small register-write port. From those comparisons it drives a shutdown output for all power channels, a low-supply status line, two warning flag lines and a fixed-length controller-reset request. It also raises six interrupt events.

Supply and temperature are tracked by separate state machines. A supply fault clears in two steps. When the supply climbs back over the fault level, one event fires, but the outputs stay off. Only when the supply reaches the higher warning level is a reset requested. A temperature fault clears only when the temperature falls to a dedicated restart level, which lies below the fault level. Each event is a one-cycle pulse that sets a sticky status bit. Software clears a status bit by writing a 1 to it. The interrupt line is the OR of the status bits that the mask enables.

Top module: `fault_supervisor`

## Requirements
- R1: Thresholds are written with `wr_en` at address 0 (supply warning), 1 (supply fault), 2 (temperature warning), 3 (temperature fault), 4 (temperature restart), using the low SW bits of `wr_data`. Address 5 writes the interrupt mask and address 6 is the status clear. A threshold step is SUP_STEP supply codes (200 mV) or TMP_STEP temperature codes (5 °C). The effective level is the threshold field times the step. Reset values are 20, 18, 20, 24 and 18, and the mask resets to 0.
- R2: The clock after `v_code` first drops below the supply warning level, event bit 0 pulses for one cycle. `vwarn_flag` is high in each cycle following a sample below that level. A code equal to the level is not below it.
- R3: The clock after `v_code` drops below the supply fault level while supply is normal, `shutdown` and `vlow` go high and event bit 1 pulses.
- R4: While in supply fault, a sample at or above the fault level pulses event bit 2 and keeps `shutdown` and `vlow` high. If the code then drops below the fault level again, event bit 1 pulses again.
- R5: While in supply fault or recovery, a sample at or above the supply warning level starts the reset request on the next clock. `shutdown` and `vlow` stay high until the request ends.
- R6: The clock after `t_code` first reaches or exceeds the temperature warning level, event bit 3 pulses. `twarn_flag` mirrors that level.
- R7: The clock after `t_code` reaches or exceeds the temperature fault level, `shutdown` goes high and event bit 4 pulses. `vlow` is unaffected.
- R8: While in temperature fault, a sample at or below the restart level pulses event bit 5 and starts the reset request.
- R9: `rst_req` stays high for exactly RST_LEN consecutive cycles. In the cycle it falls, both fault states return to normal and `shutdown`/`vlow` drop. Recovery requests are ignored while it is high.
- R10: Each event pulse sets its bit of `int_status` one clock later. A write to address 6 clears the bits where `wr_data` holds 1. An event arriving in the same cycle as the clear wins. Bits are otherwise never cleared.
- R11: `irq` is a register equal to the OR of `int_status & mask`. It follows them one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| v_code | input | VW | Digitised supply voltage |
| t_code | input | TW | Digitised die temperature |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| evt_pulse | output | 6 | One-cycle event pulses |
| int_status | output | 6 | Sticky interrupt status |
| irq | output | 1 | Masked interrupt |
| shutdown | output | 1 | Turn off all channels |
| vlow | output | 1 | Low-supply status |
| rst_req | output | 1 | Controller reset request |
| vwarn_flag | output | 1 | Supply below warning level |
| twarn_flag | output | 1 | Temperature at/above warning level |

## Verification
The bench builds the block with its default parameters. Both codes are 8 bits wide, the steps are 8 supply codes and 5 temperature codes, and the reset request lasts 16 cycles. The reset thresholds therefore land on exact codes: 160, 144, 100, 120 and 90. These values let the vector table hit each level exactly, one code beyond it, and a refault from recovery, and they let it count every cycle of the reset pulse. A reprogrammed warning threshold of 25 steps moves the supply boundary to code 200. This shows that the scaling by the step constant takes effect at run time.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int NEV       = 6;
  localparam int EV_VWARN  = 0;
  localparam int EV_VACT   = 1;
  localparam int EV_VINACT = 2;
  localparam int EV_TWARN  = 3;
  localparam int EV_TOVER  = 4;
  localparam int EV_TUNDER = 5;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_VWARN = 3'd0;
  localparam logic [ADDR_W-1:0] A_VFLT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TWARN = 3'd2;
  localparam logic [ADDR_W-1:0] A_TFLT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRST  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd6;

  typedef enum logic [1:0] {VS_OK, VS_FLT, VS_REC} vstate_t;
  typedef enum logic {TS_OK, TS_FLT} tstate_t;
endpackage

// File: rtl/fsup_vmon.sv
module fsup_vmon #(
  parameter int VW   = 8,
  parameter int SW   = 5,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] code,
  input  logic [SW-1:0] warn_thr,
  input  logic [SW-1:0] flt_thr,
  input  logic          hold,
  input  logic          done,
  output logic          ev_warn,
  output logic          ev_act,
  output logic          ev_inact,
  output logic          trig,
  output logic          fault,
  output logic          warn_flag
);
  import fsup_pkg::*;
  localparam int CW = VW + SW + 8;

  logic [CW-1:0] code_x, warn_lvl, flt_lvl;
  logic          lt_warn, lt_flt, lt_warn_q;
  vstate_t       st;

  assign code_x   = CW'(code);
  assign warn_lvl = CW'(warn_thr) * CW'(STEP);
  assign flt_lvl  = CW'(flt_thr) * CW'(STEP);
  assign lt_warn  = code_x < warn_lvl;
  assign lt_flt   = code_x < flt_lvl;
  assign fault    = (st != VS_OK);

  always_comb trig = (st != VS_OK) && !hold && !lt_flt && !lt_warn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= VS_OK;
      lt_warn_q <= 1'b0;
      warn_flag <= 1'b0;
      ev_warn   <= 1'b0;
      ev_act    <= 1'b0;
      ev_inact  <= 1'b0;
    end else begin
      lt_warn_q <= lt_warn;
      warn_flag <= lt_warn;
      ev_warn   <= lt_warn && !lt_warn_q;
      ev_act    <= 1'b0;
      ev_inact  <= 1'b0;
      if (done) begin
        st <= VS_OK;
      end else begin
        case (st)
          VS_OK: if (lt_flt) begin
            st     <= VS_FLT;
            ev_act <= 1'b1;
          end
          VS_FLT: if (!lt_flt && !hold) begin
            st       <= VS_REC;
            ev_inact <= 1'b1;
          end
          VS_REC: if (lt_flt) begin
            st     <= VS_FLT;
            ev_act <= 1'b1;
          end
          default: st <= VS_OK;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsup_tmon.sv
module fsup_tmon #(
  parameter int TW   = 8,
  parameter int SW   = 5,
  parameter int STEP = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] code,
  input  logic [SW-1:0] warn_thr,
  input  logic [SW-1:0] flt_thr,
  input  logic [SW-1:0] rst_thr,
  input  logic          hold,
  input  logic          done,
  output logic          ev_warn,
  output logic          ev_over,
  output logic          ev_under,
  output logic          trig,
  output logic          fault,
  output logic          warn_flag
);
  import fsup_pkg::*;
  localparam int CW = TW + SW + 8;

  logic [CW-1:0] code_x, warn_lvl, flt_lvl, rst_lvl;
  logic          ge_warn, ge_flt, le_rst, ge_warn_q;
  tstate_t       st;

  assign code_x   = CW'(code);
  assign warn_lvl = CW'(warn_thr) * CW'(STEP);
  assign flt_lvl  = CW'(flt_thr) * CW'(STEP);
  assign rst_lvl  = CW'(rst_thr) * CW'(STEP);
  assign ge_warn  = code_x >= warn_lvl;
  assign ge_flt   = code_x >= flt_lvl;
  assign le_rst   = code_x <= rst_lvl;
  assign fault    = (st == TS_FLT);

  always_comb trig = (st == TS_FLT) && !hold && le_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TS_OK;
      ge_warn_q <= 1'b0;
      warn_flag <= 1'b0;
      ev_warn   <= 1'b0;
      ev_over   <= 1'b0;
      ev_under  <= 1'b0;
    end else begin
      ge_warn_q <= ge_warn;
      warn_flag <= ge_warn;
      ev_warn   <= ge_warn && !ge_warn_q;
      ev_over   <= 1'b0;
      ev_under  <= 1'b0;
      if (done) begin
        st <= TS_OK;
      end else if (st == TS_OK) begin
        if (ge_flt) begin
          st      <= TS_FLT;
          ev_over <= 1'b1;
        end
      end else if (le_rst && !hold) begin
        ev_under <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsup_rtimer.sv
module fsup_rtimer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic busy,
  output logic done
);
  localparam int CNW = $clog2(LEN + 1);
  logic [CNW-1:0] cnt;

  assign done = busy && (cnt == CNW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (trig) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsup_irq.sv
module fsup_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] mask,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_eff) | evt;
      irq    <= |(status & mask);
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int VW          = 8,
  parameter int TW          = 8,
  parameter int SW          = 5,
  parameter int DW          = 8,
  parameter int SUP_STEP    = 8,
  parameter int TMP_STEP    = 5,
  parameter int RST_LEN     = 16,
  parameter int V_WARN_INIT = 20,
  parameter int V_FLT_INIT  = 18,
  parameter int T_WARN_INIT = 20,
  parameter int T_FLT_INIT  = 24,
  parameter int T_RST_INIT  = 18
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [VW-1:0]                v_code,
  input  logic [TW-1:0]                t_code,
  input  logic                         wr_en,
  input  logic [fsup_pkg::ADDR_W-1:0]  wr_addr,
  input  logic [DW-1:0]                wr_data,
  output logic [fsup_pkg::NEV-1:0]     evt_pulse,
  output logic [fsup_pkg::NEV-1:0]     int_status,
  output logic                         irq,
  output logic                         shutdown,
  output logic                         vlow,
  output logic                         rst_req,
  output logic                         vwarn_flag,
  output logic                         twarn_flag
);
  import fsup_pkg::*;

  logic [SW-1:0]  vwarn_thr, vflt_thr, twarn_thr, tflt_thr, trst_thr;
  logic [NEV-1:0] mask_q;
  logic           busy, done, vtrig, ttrig, vfault, tfault, clr_we;
  logic           ev_vwarn, ev_vact, ev_vinact, ev_twarn, ev_tover, ev_tunder;

  always_ff @(posedge clk) begin
    if (rst) begin
      vwarn_thr <= SW'(V_WARN_INIT);
      vflt_thr  <= SW'(V_FLT_INIT);
      twarn_thr <= SW'(T_WARN_INIT);
      tflt_thr  <= SW'(T_FLT_INIT);
      trst_thr  <= SW'(T_RST_INIT);
      mask_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_VWARN: vwarn_thr <= wr_data[SW-1:0];
        A_VFLT:  vflt_thr  <= wr_data[SW-1:0];
        A_TWARN: twarn_thr <= wr_data[SW-1:0];
        A_TFLT:  tflt_thr  <= wr_data[SW-1:0];
        A_TRST:  trst_thr  <= wr_data[SW-1:0];
        A_MASK:  mask_q    <= wr_data[NEV-1:0];
        default: ;
      endcase
    end
  end

  assign clr_we = wr_en && (wr_addr == A_CLR);

  fsup_vmon #(.VW(VW), .SW(SW), .STEP(SUP_STEP)) u_vmon (
    .clk(clk), .rst(rst), .code(v_code),
    .warn_thr(vwarn_thr), .flt_thr(vflt_thr),
    .hold(busy), .done(done),
    .ev_warn(ev_vwarn), .ev_act(ev_vact), .ev_inact(ev_vinact),
    .trig(vtrig), .fault(vfault), .warn_flag(vwarn_flag)
  );

  fsup_tmon #(.TW(TW), .SW(SW), .STEP(TMP_STEP)) u_tmon (
    .clk(clk), .rst(rst), .code(t_code),
    .warn_thr(twarn_thr), .flt_thr(tflt_thr), .rst_thr(trst_thr),
    .hold(busy), .done(done),
    .ev_warn(ev_twarn), .ev_over(ev_tover), .ev_under(ev_tunder),
    .trig(ttrig), .fault(tfault), .warn_flag(twarn_flag)
  );

  fsup_rtimer #(.LEN(RST_LEN)) u_rtimer (
    .clk(clk), .rst(rst), .trig(vtrig | ttrig), .busy(busy), .done(done)
  );

  always_comb begin
    evt_pulse            = '0;
    evt_pulse[EV_VWARN]  = ev_vwarn;
    evt_pulse[EV_VACT]   = ev_vact;
    evt_pulse[EV_VINACT] = ev_vinact;
    evt_pulse[EV_TWARN]  = ev_twarn;
    evt_pulse[EV_TOVER]  = ev_tover;
    evt_pulse[EV_TUNDER] = ev_tunder;
  end

  fsup_irq #(.N(NEV)) u_irq (
    .clk(clk), .rst(rst), .evt(evt_pulse), .mask(mask_q),
    .clr_we(clr_we), .clr_bits(wr_data[NEV-1:0]),
    .status(int_status), .irq(irq)
  );

  assign rst_req  = busy;
  assign vlow     = vfault;
  assign shutdown = vfault | tfault;
endmodule

// File: rtl/fsup_chk.sv
module fsup_chk #(
  parameter int RST_LEN = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic [fsup_pkg::NEV-1:0]    evt_pulse,
  input logic [fsup_pkg::NEV-1:0]    int_status,
  input logic                        shutdown,
  input logic                        vlow,
  input logic                        rst_req,
  input logic                        wr_en,
  input logic [fsup_pkg::ADDR_W-1:0] wr_addr
);
  import fsup_pkg::*;
  localparam int HW = $clog2(RST_LEN + 2) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= '0;
    else if (rst_req) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  // R9
  rst_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> hi_cnt == HW'(RST_LEN));
  // R9
  rst_max_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> hi_cnt < HW'(RST_LEN));
  // R3
  vlow_sd_chk: assert property (@(posedge clk) disable iff (rst)
    vlow |-> shutdown);
  // R7
  over_sd_chk: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[EV_TOVER] |-> shutdown);
  // R5
  rst_sd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> shutdown);
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_CLR) |=> ((int_status & $past(int_status)) == $past(int_status)));

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    // R2
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
      evt_pulse[i] |=> !evt_pulse[i]);
    // R10
    set_chk: assert property (@(posedge clk) disable iff (rst)
      evt_pulse[i] |=> int_status[i]);
  end
endmodule

bind fault_supervisor fsup_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .int_status(int_status),
  .shutdown(shutdown), .vlow(vlow), .rst_req(rst_req),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] v_code, t_code;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [5:0] evt_pulse, int_status;
  logic       irq, shutdown, vlow, rst_req, vwarn_flag, twarn_flag;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fault_supervisor u0 (
    .clk(clk), .rst(rst), .v_code(v_code), .t_code(t_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_pulse(evt_pulse), .int_status(int_status), .irq(irq),
    .shutdown(shutdown), .vlow(vlow), .rst_req(rst_req),
    .vwarn_flag(vwarn_flag), .twarn_flag(twarn_flag)
  );

  typedef struct packed {
    logic [7:0] v;
    logic [7:0] t;
    logic [5:0] ev;
    logic       sd;
    logic       lo;
    logic       rr;
    logic [4:0] reps;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{8'd200, 8'd50,  6'h00, 1'b0, 1'b0, 1'b0, 5'd1,  4'd2},  // R2 idle
    '{8'd160, 8'd50,  6'h00, 1'b0, 1'b0, 1'b0, 5'd1,  4'd2},  // R2 equal, not below
    '{8'd159, 8'd50,  6'h01, 1'b0, 1'b0, 1'b0, 5'd1,  4'd2},  // R2 warn edge
    '{8'd150, 8'd50,  6'h00, 1'b0, 1'b0, 1'b0, 5'd1,  4'd2},  // R2 no repeat
    '{8'd143, 8'd50,  6'h02, 1'b1, 1'b1, 1'b0, 5'd1,  4'd3},  // R3 fault
    '{8'd140, 8'd50,  6'h00, 1'b1, 1'b1, 1'b0, 5'd1,  4'd3},  // R3 held
    '{8'd144, 8'd50,  6'h04, 1'b1, 1'b1, 1'b0, 5'd1,  4'd4},  // R4 inactive
    '{8'd150, 8'd50,  6'h00, 1'b1, 1'b1, 1'b0, 5'd1,  4'd4},  // R4 still off
    '{8'd143, 8'd50,  6'h02, 1'b1, 1'b1, 1'b0, 5'd1,  4'd4},  // R4 refault
    '{8'd160, 8'd50,  6'h04, 1'b1, 1'b1, 1'b1, 5'd1,  4'd5},  // R5 reset starts
    '{8'd200, 8'd50,  6'h00, 1'b1, 1'b1, 1'b1, 5'd15, 4'd9},  // R9 pulse body
    '{8'd200, 8'd50,  6'h00, 1'b0, 1'b0, 1'b0, 5'd1,  4'd9},  // R9 end, cleared
    '{8'd200, 8'd99,  6'h00, 1'b0, 1'b0, 1'b0, 5'd1,  4'd6},  // R6 below
    '{8'd200, 8'd100, 6'h08, 1'b0, 1'b0, 1'b0, 5'd1,  4'd6},  // R6 warn edge
    '{8'd200, 8'd120, 6'h10, 1'b1, 1'b0, 1'b0, 5'd1,  4'd7},  // R7 over
    '{8'd200, 8'd95,  6'h00, 1'b1, 1'b0, 1'b0, 5'd1,  4'd8},  // R8 above restart
    '{8'd200, 8'd90,  6'h20, 1'b1, 1'b0, 1'b1, 5'd1,  4'd8},  // R8 under + reset
    '{8'd200, 8'd50,  6'h00, 1'b1, 1'b0, 1'b1, 5'd15, 4'd9},  // R9 pulse body
    '{8'd200, 8'd50,  6'h00, 1'b0, 1'b0, 1'b0, 5'd1,  4'd9}   // R9 end
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    rst = 1'b1; v_code = 8'd200; t_code = 8'd50;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({evt_pulse, int_status, irq, shutdown, vlow, rst_req} == '0, "R9 reset state",
          {evt_pulse, int_status, irq, shutdown, vlow, rst_req}, 0);

    for (int i = 0; i < NV; i++) begin
      for (int r = 0; r < int'(TBL[i].reps); r++) begin
        v_code = TBL[i].v; t_code = TBL[i].t;
        @(negedge clk);
        check({evt_pulse, shutdown, vlow, rst_req} == {TBL[i].ev, TBL[i].sd, TBL[i].lo, TBL[i].rr},
              $sformatf("R%0d vector %0d", TBL[i].req, i),
              {evt_pulse, shutdown, vlow, rst_req}, {TBL[i].ev, TBL[i].sd, TBL[i].lo, TBL[i].rr});
      end
    end

    // R10 all events seen; R11 mask is zero
    check(int_status == 6'h3F, "R10 sticky all", int_status, 6'h3F);
    check(irq == 1'b0, "R11 masked off", irq, 0);
    wr(3'd5, 8'h10);
    @(negedge clk);
    check(irq == 1'b1, "R11 mask enables", irq, 1);
    wr(3'd6, 8'h10);
    check(int_status == 6'h2F, "R10 w1c one bit", int_status, 6'h2F);
    @(negedge clk);
    check(irq == 1'b0, "R11 irq follows clear", irq, 0);
    wr(3'd6, 8'h3F);
    check(int_status == 6'h00, "R10 w1c all", int_status, 0);

    // R1 raise supply warning to 25 steps = code 200
    wr(3'd0, 8'd25);
    v_code = 8'd199;
    @(negedge clk);
    check(evt_pulse == 6'h01, "R1 reprogrammed warn event", evt_pulse, 6'h01);
    check(vwarn_flag == 1'b1, "R2 warn flag high", vwarn_flag, 1);
    v_code = 8'd200;
    @(negedge clk);
    check(vwarn_flag == 1'b0, "R2 warn flag low at level", vwarn_flag, 0);
    check(shutdown == 1'b0, "R1 no fault at 199", shutdown, 0);

    // R6 temperature flag
    t_code = 8'd105;
    @(negedge clk);
    check(twarn_flag == 1'b1 && evt_pulse == 6'h08, "R6 temp flag and event",
          {twarn_flag, evt_pulse}, {1'b1, 6'h08});
    t_code = 8'd50;
    @(negedge clk);
    check(twarn_flag == 1'b0, "R6 temp flag drops", twarn_flag, 0);
    wr(3'd6, 8'h3F);
    check(int_status == 6'h00, "R10 cleared before race", int_status, 0);

    // R10 event and clear in the same cycle: set wins
    t_code = 8'd105;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h08;
    @(negedge clk);
    wr_en = 1'b0;
    check(int_status[3] == 1'b1, "R10 set wins over clear", int_status, 6'h08);

    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule